// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right word clock of a stereo serial audio link from a fast master audio clock. All of its logic runs on that master clock. In master mode it divides the master clock down to a bit clock and counts bit clocks into frames. In slave mode it forwards a bit clock and word clock that arrive from outside, and it detects their edges through a synchronizer.

Both modes raise single-cycle strobes in the master clock domain. One marks each bit launch edge and the other marks each frame start, and serializers downstream move data on these strobes. Ratio and polarity settings for master mode are held in a shadow copy. That copy is refreshed only while the generator is stopped or at the last bit of a frame, so a change never splits a frame.

Top module: `aclk_gen`

## Requirements
- R1: During and right after reset, `bit_stb`, `frame_stb` and `clk_oe` are low.
- R2: In master mode, `cfg_bdiv_sel` picks a bit period of 2 (value 0) or 4 (value 1) master clocks. After `cfg_enable` rises, the first `bit_stb` is registered on the first clock edge with the divide-by-2 ratio, or on the second edge with the divide-by-4 ratio. After that, `bit_stb` repeats exactly once per bit period and is never high in two consecutive cycles.
- R3: `cfg_frame_sel` sets the frame length: 00 gives 32 bits, 01 gives 64 bits, and 10 or 11 gives 128 bits. `frame_stb` is raised together with the `bit_stb` of bit 0 of every frame. The first bit after enable is bit 0.
- R4: In master mode, `lrclk_o` equals `cfg_lr_inv` for the first half of the bits of a frame, and its inverse for the second half.
- R5: In master mode, the active bit clock edge is a falling edge of `bclk_o` when `cfg_bclk_inv`=0 and a rising edge when it is 1. In the cycle that `bit_stb` is high, `bclk_o` equals `cfg_bclk_inv`.
- R6: While `cfg_enable` is low, no strobe is raised. In master mode, `bclk_o` then rests at the inverse of `cfg_bclk_inv` and `lrclk_o` rests at `cfg_lr_inv`.
- R7: When `cfg_free_run`=0 and `xfer_active`=0, `bclk_o` is held at its resting level. The strobes and `lrclk_o` keep running.
- R8: A change of ratio or polarity settings during a master run does not affect the frame in progress. The new settings are taken at the launch of that frame's last bit, and the next frame is produced entirely with the new settings.
- R9: In slave mode, `bclk_o` and `lrclk_o` follow `ext_bclk` and `ext_lrclk`. A bit launch edge is a falling edge of `ext_bclk` when `cfg_bclk_inv`=0, or a rising edge when it is 1; the other edge is ignored. A frame start is a change of `ext_lrclk` to the level `cfg_lr_inv`. Each strobe rises 3 clock edges after the input changes.
- R10: `clk_oe` is high exactly when both `cfg_master` and `cfg_enable` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global run enable |
| cfg_master | input | 1 | 1: generate clocks, 0: accept external clocks |
| cfg_bdiv_sel | input | 1 | Bit period select (0: 2, 1: 4 master clocks) |
| cfg_frame_sel | input | 2 | Frame length select (32/64/128) |
| cfg_bclk_inv | input | 1 | Bit clock polarity |
| cfg_lr_inv | input | 1 | Word clock polarity |
| cfg_free_run | input | 1 | 1: bit clock never gated |
| xfer_active | input | 1 | Data movement in progress (allows the bit clock when gating) |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External word clock (slave mode) |
| bclk_o | output | 1 | Bit clock out |
| lrclk_o | output | 1 | Word clock out |
| clk_oe | output | 1 | Pad drive enable for the two clocks |
| bit_stb | output | 1 | One-cycle strobe at each bit launch edge |
| frame_stb | output | 1 | One-cycle strobe at each frame start |

## Verification
Master strobes are registered on the same edge that moves the internal bit clock. For each run the bench therefore computes exact frame start cycles (enable edge, plus half the bit period minus one, plus multiples of ratio times frame length), queues them, and the monitor compares each observed `frame_stb` against that queue. For a mid-run setting change, the next frame start is due one new bit period after the old frame's last bit. In slave mode, each strobe is expected on the third edge after the external input changes, and the bench counts strobes in a four-cycle window to catch both early and missing ones. All outputs are sampled one time unit after the falling clock edge.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef struct packed {
    logic       bdiv_sel;
    logic [1:0] frame_sel;
    logic       bclk_inv;
    logic       lr_inv;
  } aclk_cfg_t;
endpackage

// File: rtl/aclk_master.sv
module aclk_master
  import aclk_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 4,
  parameter int FR_A  = 32,
  parameter int FR_B  = 64,
  parameter int FR_C  = 128
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  aclk_cfg_t cfg_in,
  output logic      bclk_inv_o,
  output logic      lr_inv_o,
  output logic      lvl_o,
  output logic      lr_o,
  output logic      bit_stb_o,
  output logic      frame_stb_o
);
  localparam int HALF_MAX = ((DIV_A > DIV_B) ? DIV_A : DIV_B) / 2;
  localparam int CW       = $clog2(HALF_MAX) + 1;
  localparam int FR_AB    = (FR_A > FR_B) ? FR_A : FR_B;
  localparam int FR_MAX   = (FR_AB > FR_C) ? FR_AB : FR_C;
  localparam int IW       = $clog2(FR_MAX);

  aclk_cfg_t       act_q, act_d;
  logic [CW-1:0]   div_q, div_d, half_m1;
  logic [IW-1:0]   idx_q, idx_d, last_c, mid_c;
  logic            lvl_q, lvl_d, lr_q, lr_d, bit_q, bit_d, frm_q, frm_d;
  logic            tick;

  // ratio decode from the shadow copy
  always_comb begin
    half_m1 = act_q.bdiv_sel ? CW'(DIV_B / 2 - 1) : CW'(DIV_A / 2 - 1);
    case (act_q.frame_sel)
      2'b00:   begin last_c = IW'(FR_A - 1); mid_c = IW'(FR_A / 2); end
      2'b01:   begin last_c = IW'(FR_B - 1); mid_c = IW'(FR_B / 2); end
      default: begin last_c = IW'(FR_C - 1); mid_c = IW'(FR_C / 2); end
    endcase
  end

  assign tick = (div_q == half_m1);

  // next state
  always_comb begin
    div_d = div_q;
    lvl_d = lvl_q;
    idx_d = idx_q;
    lr_d  = lr_q;
    act_d = act_q;
    bit_d = 1'b0;
    frm_d = 1'b0;
    if (!run) begin
      div_d = '0;
      lvl_d = 1'b1;
      idx_d = '0;
      lr_d  = 1'b0;
      act_d = cfg_in;
    end else if (tick) begin
      div_d = '0;
      lvl_d = ~lvl_q;
      if (lvl_q) begin
        bit_d = 1'b1;
        frm_d = (idx_q == '0);
        lr_d  = (idx_q >= mid_c);
        if (idx_q == last_c) begin
          idx_d = '0;
          act_d = cfg_in;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lvl_q <= 1'b1;
      idx_q <= '0;
      lr_q  <= 1'b0;
      act_q <= '0;
      bit_q <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      div_q <= div_d;
      lvl_q <= lvl_d;
      idx_q <= idx_d;
      lr_q  <= lr_d;
      act_q <= act_d;
      bit_q <= bit_d;
      frm_q <= frm_d;
    end
  end

  assign bclk_inv_o  = act_q.bclk_inv;
  assign lr_inv_o    = act_q.lr_inv;
  assign lvl_o       = lvl_q;
  assign lr_o        = lr_q;
  assign bit_stb_o   = bit_q;
  assign frame_stb_o = frm_q;

  // R2
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q |=> !bit_q);
  // R3
  frame_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q |-> bit_q);
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_c);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lvl_q && !lr_q && !bit_q));
endmodule

// File: rtl/aclk_slave.sv
module aclk_slave (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_inv,
  input  logic lr_inv,
  input  logic ext_bclk,
  input  logic ext_lrclk,
  output logic bit_stb_o,
  output logic frame_stb_o
);
  logic [2:0] b_sh_q, b_sh_d, l_sh_q, l_sh_d;
  logic       b_rise, b_fall, launch, frame_c;
  logic       bit_q, bit_d, frm_q, frm_d;

  always_comb begin
    b_sh_d  = {b_sh_q[1:0], ext_bclk};
    l_sh_d  = {l_sh_q[1:0], ext_lrclk};
    b_rise  = b_sh_q[1] & ~b_sh_q[2];
    b_fall  = ~b_sh_q[1] & b_sh_q[2];
    launch  = bclk_inv ? b_rise : b_fall;
    frame_c = ((l_sh_q[2] ^ lr_inv) == 1'b1) && ((l_sh_q[1] ^ lr_inv) == 1'b0);
    bit_d   = en & launch;
    frm_d   = en & frame_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sh_q <= '0;
      l_sh_q <= '0;
      bit_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      b_sh_q <= b_sh_d;
      l_sh_q <= l_sh_d;
      bit_q  <= bit_d;
      frm_q  <= frm_d;
    end
  end

  assign bit_stb_o   = bit_q;
  assign frame_stb_o = frm_q;

  // R9
  slave_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bit_q && !frm_q));
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 4,
  parameter int FR_A  = 32,
  parameter int FR_B  = 64,
  parameter int FR_C  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_enable,
  input  logic       cfg_master,
  input  logic       cfg_bdiv_sel,
  input  logic [1:0] cfg_frame_sel,
  input  logic       cfg_bclk_inv,
  input  logic       cfg_lr_inv,
  input  logic       cfg_free_run,
  input  logic       xfer_active,
  input  logic       ext_bclk,
  input  logic       ext_lrclk,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       clk_oe,
  output logic       bit_stb,
  output logic       frame_stb
);
  aclk_cfg_t cfg_w;
  logic m_run, s_en, gate_c;
  logic m_binv, m_linv, m_lvl, m_lr, m_bit, m_frm;
  logic s_bit, s_frm;

  assign cfg_w = '{bdiv_sel: cfg_bdiv_sel, frame_sel: cfg_frame_sel,
                   bclk_inv: cfg_bclk_inv, lr_inv: cfg_lr_inv};
  assign m_run  = cfg_enable & cfg_master;
  assign s_en   = cfg_enable & ~cfg_master;
  assign gate_c = ~cfg_free_run & ~xfer_active;

  aclk_master #(.DIV_A(DIV_A), .DIV_B(DIV_B), .FR_A(FR_A), .FR_B(FR_B), .FR_C(FR_C)) u_mst (
    .clk(clk), .rst_n(rst_n), .run(m_run), .cfg_in(cfg_w),
    .bclk_inv_o(m_binv), .lr_inv_o(m_linv), .lvl_o(m_lvl), .lr_o(m_lr),
    .bit_stb_o(m_bit), .frame_stb_o(m_frm)
  );

  aclk_slave u_slv (
    .clk(clk), .rst_n(rst_n), .en(s_en), .bclk_inv(cfg_bclk_inv), .lr_inv(cfg_lr_inv),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
    .bit_stb_o(s_bit), .frame_stb_o(s_frm)
  );

  always_comb begin
    if (cfg_master) begin
      bclk_o    = (gate_c | m_lvl) ^ m_binv;
      lrclk_o   = m_lr ^ m_linv;
      bit_stb   = m_bit;
      frame_stb = m_frm;
    end else begin
      bclk_o    = ext_bclk;
      lrclk_o   = ext_lrclk;
      bit_stb   = s_bit;
      frame_stb = s_frm;
    end
  end

  assign clk_oe = m_run;

  // R6
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && $stable(cfg_master)) |=> (!bit_stb && !frame_stb));
endmodule

// File: tb/sim_aclk_gen.sv
module sim_aclk_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, cfg_enable, cfg_master, cfg_bdiv_sel, cfg_bclk_inv, cfg_lr_inv;
  logic cfg_free_run, xfer_active, ext_bclk, ext_lrclk;
  logic [1:0] cfg_frame_sel;
  logic bclk_o, lrclk_o, clk_oe, bit_stb, frame_stb;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit mon_on = 0, mon_binv = 0, mon_linv = 0, mon_gated = 0, have_last = 0;
  int mon_ratio = 2, mon_flen = 32, last_bit = 0, bitpos = 0;

  aclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_bdiv_sel(cfg_bdiv_sel), .cfg_frame_sel(cfg_frame_sel),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_lr_inv(cfg_lr_inv),
    .cfg_free_run(cfg_free_run), .xfer_active(xfer_active),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .clk_oe(clk_oe),
    .bit_stb(bit_stb), .frame_stb(frame_stb)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected frame starts, checks per-bit levels
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (frame_stb) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected frame start", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R3 frame start cycle", cyc, e);
        end
        bitpos = 0;
      end else if (bit_stb) begin
        bitpos++;
      end
      if (bit_stb && mon_on) begin
        if (have_last) chk(cyc - last_bit == mon_ratio, "R2 bit period", cyc - last_bit, mon_ratio);
        chk(lrclk_o == (mon_linv ^ (bitpos >= mon_flen / 2)), "R4 lrclk level",
            int'(lrclk_o), int'(mon_linv ^ (bitpos >= mon_flen / 2)));
        chk(bclk_o == (mon_gated ? !mon_binv : mon_binv), "R5/R7 bclk level at launch",
            int'(bclk_o), int'(mon_gated ? !mon_binv : mon_binv));
        last_bit  = cyc;
        have_last = 1;
      end
    end
  end

  task automatic run_master(bit bd, logic [1:0] fs, bit bi, bit li, bit gate, int nfr);
    int half, ratio, flen, k, tend, hits;
    @(negedge clk);
    cfg_master = 1; cfg_bdiv_sel = bd; cfg_frame_sel = fs;
    cfg_bclk_inv = bi; cfg_lr_inv = li; cfg_free_run = !gate; xfer_active = 0;
    repeat (2) @(negedge clk);
    #1;
    // R6 idle levels with master selected and generator stopped
    chk(bclk_o == !bi, "R6 idle bclk", int'(bclk_o), int'(!bi));
    chk(lrclk_o == li, "R6 idle lrclk", int'(lrclk_o), int'(li));
    chk(clk_oe == 0, "R10 oe off while stopped", int'(clk_oe), 0);
    half  = bd ? 2 : 1;
    ratio = 2 * half;
    flen  = (fs == 2'b00) ? 32 : (fs == 2'b01) ? 64 : 128;
    mon_ratio = ratio; mon_flen = flen; mon_binv = bi; mon_linv = li;
    mon_gated = gate; have_last = 0; mon_on = 1;
    cfg_enable = 1;
    k = cyc + 1;
    for (int n = 0; n < nfr; n++) exp_q.push_back(k + half - 1 + n * ratio * flen);
    tend = k + half - 1 + nfr * ratio * flen - 1;
    #1;
    chk(clk_oe == 1, "R10 oe on while running", int'(clk_oe), 1);
    while (cyc < tend) @(negedge clk);
    cfg_enable = 0;
    mon_on = 0;
    hits = 0;
    repeat (12) begin
      @(negedge clk);
      #1;
      if (bit_stb) hits++;
    end
    chk(hits == 0, "R6 no strobes after disable", hits, 0);
    chk(exp_q.size() == 0, "R3 all frame starts seen", exp_q.size(), 0);
  endtask

  task automatic slave_bit(bit val, int exp_stb);
    int c, hits;
    @(negedge clk);
    ext_bclk = val;
    c = cyc;
    hits = 0;
    #1;
    chk(bclk_o == val, "R9 bclk passthrough", int'(bclk_o), int'(val));
    repeat (4) begin
      @(negedge clk);
      #1;
      if (bit_stb) begin
        hits++;
        chk(cyc == c + 3, "R9 strobe latency", cyc, c + 3);
      end
    end
    chk(hits == exp_stb, "R9 bit strobe count", hits, exp_stb);
  endtask

  task automatic slave_lr(bit val, bit exp_frm);
    @(negedge clk);
    ext_lrclk = val;
    if (exp_frm) exp_q.push_back(cyc + 3);
    #1;
    chk(lrclk_o == val, "R9 lrclk passthrough", int'(lrclk_o), int'(val));
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9 frame strobe seen", exp_q.size(), 0);
  endtask

  initial begin
    int k, t1, t2;
    rst_n = 0; cfg_enable = 0; cfg_master = 0; cfg_bdiv_sel = 0; cfg_frame_sel = 2'b00;
    cfg_bclk_inv = 0; cfg_lr_inv = 0; cfg_free_run = 1; xfer_active = 0;
    ext_bclk = 0; ext_lrclk = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(bit_stb == 0, "R1 bit strobe in reset", int'(bit_stb), 0);
    chk(frame_stb == 0, "R1 frame strobe in reset", int'(frame_stb), 0);
    chk(clk_oe == 0, "R1 oe in reset", int'(clk_oe), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(bit_stb == 0 && frame_stb == 0, "R1 strobes after reset", int'(bit_stb), 0);

    // R2 R3 R4 R5 across ratios, frame lengths, polarities
    run_master(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 3);
    run_master(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 2);
    run_master(1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1);
    run_master(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1);
    // R7 gated bit clock
    run_master(1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 2);
    run_master(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1);

    // R8 settings change mid-frame applies from the next frame
    @(negedge clk);
    cfg_master = 1; cfg_bdiv_sel = 0; cfg_frame_sel = 2'b00; cfg_free_run = 1;
    cfg_bclk_inv = 0; cfg_lr_inv = 0;
    repeat (2) @(negedge clk);
    cfg_enable = 1;
    k = cyc + 1;
    exp_q.push_back(k);
    while (cyc < k + 5) @(negedge clk);
    cfg_bdiv_sel = 1; cfg_frame_sel = 2'b01;
    t1 = k + 31 * 2 + 4;
    t2 = t1 + 64 * 4;
    exp_q.push_back(t1);
    exp_q.push_back(t2);
    while (cyc < t2 + 255) @(negedge clk);
    cfg_enable = 0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R8 frame starts after change", exp_q.size(), 0);

    // R9 slave mode
    @(negedge clk);
    cfg_master = 0; cfg_bclk_inv = 0; cfg_lr_inv = 0;
    ext_bclk = 1; ext_lrclk = 1;
    cfg_enable = 1;
    repeat (5) @(negedge clk);
    #1;
    chk(clk_oe == 0, "R10 oe off in slave mode", int'(clk_oe), 0);
    slave_bit(1'b0, 1);
    slave_bit(1'b1, 0);
    @(negedge clk);
    cfg_bclk_inv = 1;
    repeat (4) @(negedge clk);
    slave_bit(1'b0, 0);
    slave_bit(1'b1, 1);
    slave_lr(1'b0, 1'b1);
    slave_lr(1'b1, 1'b0);
    @(negedge clk);
    cfg_lr_inv = 1;
    repeat (4) @(negedge clk);
    slave_lr(1'b0, 1'b0);
    slave_lr(1'b1, 1'b1);
    // R6 slave strobes off when disabled
    @(negedge clk);
    cfg_enable = 0;
    slave_bit(1'b0, 0);
    slave_bit(1'b1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1..: run did not finish actual=%0d expected=%0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule